// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block is the hardware loop unit of a small DSP sequencer. A block-repeat start command brings a repeat count, an end address and the address of the command itself. The block records a loop context and then watches each fetch address. The context holds the first body address, the last body address and a live counter. The first body address is the word after the two-word command. When fetch reaches the last body address, the block either sends fetch back to the first body address or lets it continue past the block.

Up to four contexts nest on an internal stack. An inner loop that finishes pops its context, and the enclosing loop carries on from its saved state. The live counter, an in-loop flag and the nesting depth are visible at all times. While an interrupt is being serviced, address matches are ignored, so the service routine's fetches cannot disturb the loops.

A three-state sequencer tracks the loop condition:
- `ST_IDLE`: no loop is open.
- `ST_ACTIVE`: one or more loops are open and no interrupt is present.
- `ST_SUSPEND`: loops are open and an interrupt is present.

The transitions are named as follows:
- `IDLE->ACTIVE`: a start is accepted with no interrupt.
- `IDLE->SUSPEND`: a start is accepted with an interrupt present.
- `ACTIVE->SUSPEND`: an interrupt rises.
- `SUSPEND->ACTIVE`: the interrupt is released.
- `ACTIVE->IDLE` and `SUSPEND->IDLE`: the last context is popped.

Top module: `loop_ctrl`

## Requirements
- R1: After reset, nest_level is 0, in_loop is 0, lc_value is 0, redirect is 0 and overflow_err is 0.
- R2: An accepted start loads the counter with the full 16-bit start_count when start_imm is 0. In the next cycle in_loop is 1 and nest_level has risen by one.
- R3: When start_imm is 1, the counter receives start_count[7:0] and its upper 8 bits are cleared, giving 1 to 256 passes.
- R4: A valid fetch at the top context's end address with a nonzero counter raises redirect, with redirect_pc equal to the command's start_pc plus 2, and the counter decrements by one. A count of N therefore gives N+1 passes.
- R5: A valid fetch at the end address with a counter of 0 gives no redirect. The context is popped and nest_level falls by one.
- R6: A pop restores the enclosing loop's counter and addresses. in_loop stays 1 while nest_level is nonzero and is 0 exactly when nest_level is 0.
- R7: A start while four contexts are open (and no pop happens in that cycle) is ignored: nest_level and lc_value are unchanged. It also sets overflow_err, which stays set until reset.
- R8: While irq_active is 1, end-address matches produce no redirect. lc_value and nest_level hold, unless a start is accepted.
- R9: When an end match and a start fall in the same cycle, the match acts on the current top context first and the new context is then pushed. A match that pops at depth 1 together with a start leaves nest_level at 1, holding the new count.
- R10: No redirect is raised when fetch_valid is 0 or when no loop is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Block-repeat start command present |
| start_imm | input | 1 | 1: count is an 8-bit immediate in start_count[7:0] |
| start_count | input | 16 | Repeat operand (passes minus one) |
| start_pc | input | 16 | Address of the start command's first word |
| start_end | input | 16 | Last address of the repeated block |
| fetch_valid | input | 1 | fetch_pc holds a real fetch this cycle |
| fetch_pc | input | 16 | Current fetch address |
| irq_active | input | 1 | Interrupt service in progress |
| redirect | output | 1 | Next fetch goes to redirect_pc |
| redirect_pc | output | 16 | First body address of the top loop |
| lc_value | output | 16 | Live counter of the top loop (0 when idle) |
| in_loop | output | 1 | At least one loop is open |
| nest_level | output | 3 | Number of open loops, 0 to 4 |
| overflow_err | output | 1 | Sticky flag: a start arrived at full depth |

## Verification
The case of interest is an end-address match and a start command landing in the same cycle. The test opens a loop whose count is spent, then presents a fetch at its end address together with a new start. It judges the result by three things. There must be no redirect. nest_level must stay at 1 with lc_value equal to the new count. The next fetch at the new loop's end must jump to the new start address. A second pairing puts an interrupt on the same cycle as an end match. The test then checks that neither a redirect nor a counter change follows, and that the match takes effect once the interrupt is gone.

// File: rtl/loop_pkg.sv
package loop_pkg;
    parameter int unsigned LP_ADDR_W    = 16;
    parameter int unsigned LP_CNT_W     = 16;
    parameter int unsigned LP_IMM_W     = 8;
    parameter int unsigned LP_DEPTH     = 4;
    parameter int unsigned LP_CMD_WORDS = 2;

    typedef logic [LP_ADDR_W-1:0] addr_t;
    typedef logic [LP_CNT_W-1:0]  cnt_t;

    typedef struct packed {
        addr_t first_pc;
        addr_t last_pc;
        cnt_t  lc;
    } loop_ctx_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_SUSPEND = 2'd2
    } loop_state_t;
endpackage

// File: rtl/loop_ctx_stack.sv
module loop_ctx_stack
    import loop_pkg::*;
#(
    parameter int unsigned DEPTH = LP_DEPTH,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             dec,
    input  loop_ctx_t        push_ctx,
    output logic [LVL_W-1:0] level,
    output loop_ctx_t        top_ctx
);
    loop_ctx_t        ctx_q [DEPTH];
    logic [LVL_W-1:0] level_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    assign top_idx = IDX_W'(level_q - LVL_W'(1));
    // A pop and a push in one cycle replace the top entry.
    assign wr_idx  = pop ? top_idx : IDX_W'(level_q);
    assign top_ctx = (level_q != '0) ? ctx_q[top_idx] : '0;
    assign level   = level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            for (int i = 0; i < int'(DEPTH); i++) begin
                ctx_q[i] <= '0;
            end
        end else begin
            level_q <= level_q + LVL_W'(push) - LVL_W'(pop);
            for (int i = 0; i < int'(DEPTH); i++) begin
                if (push && (IDX_W'(i) == wr_idx)) begin
                    ctx_q[i] <= push_ctx;
                end else if (dec && (IDX_W'(i) == top_idx)) begin
                    ctx_q[i].lc <= ctx_q[i].lc - cnt_t'(1);
                end
            end
        end
    end
endmodule

// File: rtl/loop_end_match.sv
module loop_end_match
    import loop_pkg::*;
(
    input  logic      fetch_valid,
    input  addr_t     fetch_pc,
    input  logic      irq_active,
    input  logic      any_open,
    input  loop_ctx_t top_ctx,
    output logic      redirect,
    output addr_t     redirect_pc,
    output logic      pop,
    output logic      dec
);
    logic hit;
    logic spent;

    assign hit         = fetch_valid && !irq_active && any_open
                         && (fetch_pc == top_ctx.last_pc);
    assign spent       = (top_ctx.lc == '0);
    assign redirect    = hit && !spent;
    assign dec         = hit && !spent;
    assign pop         = hit && spent;
    assign redirect_pc = top_ctx.first_pc;
endmodule

// File: rtl/loop_seq_fsm.sv
module loop_seq_fsm
    import loop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_active,
    input  logic open_next,
    input  logic overflow_evt,
    output logic in_loop,
    output logic overflow_err
);
    loop_state_t state_q;
    loop_state_t state_d;
    logic        err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (open_next) state_d = irq_active ? ST_SUSPEND : ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (!open_next)     state_d = ST_IDLE;
                else if (irq_active) state_d = ST_SUSPEND;
            end
            ST_SUSPEND: begin
                if (!open_next)      state_d = ST_IDLE;
                else if (!irq_active) state_d = ST_ACTIVE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            err_q <= 1'b0;
        else if (overflow_evt) err_q <= 1'b1;
    end

    always_comb begin
        in_loop      = (state_q != ST_IDLE);
        overflow_err = err_q;
    end
endmodule

// File: rtl/loop_ctrl.sv
module loop_ctrl
    import loop_pkg::*;
#(
    parameter int unsigned DEPTH     = LP_DEPTH,
    parameter int unsigned CMD_WORDS = LP_CMD_WORDS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_valid,
    input  logic                         start_imm,
    input  logic [LP_CNT_W-1:0]          start_count,
    input  logic [LP_ADDR_W-1:0]         start_pc,
    input  logic [LP_ADDR_W-1:0]         start_end,
    input  logic                         fetch_valid,
    input  logic [LP_ADDR_W-1:0]         fetch_pc,
    input  logic                         irq_active,
    output logic                         redirect,
    output logic [LP_ADDR_W-1:0]         redirect_pc,
    output logic [LP_CNT_W-1:0]          lc_value,
    output logic                         in_loop,
    output logic [$clog2(DEPTH+1)-1:0]   nest_level,
    output logic                         overflow_err
);
    localparam int unsigned LVL_W = $clog2(DEPTH + 1);

    loop_ctx_t        top_ctx;
    loop_ctx_t        new_ctx;
    logic [LVL_W-1:0] level;
    logic [LVL_W-1:0] level_after_pop;
    logic             pop;
    logic             dec;
    logic             push;
    logic             overflow_evt;
    logic             open_next;
    cnt_t             load_cnt;

    always_comb begin
        if (start_imm) load_cnt = {{(LP_CNT_W-LP_IMM_W){1'b0}}, start_count[LP_IMM_W-1:0]};
        else           load_cnt = start_count;
        new_ctx.first_pc = start_pc + addr_t'(CMD_WORDS);
        new_ctx.last_pc  = start_end;
        new_ctx.lc       = load_cnt;
    end

    loop_end_match u_match (
        .fetch_valid (fetch_valid),
        .fetch_pc    (fetch_pc),
        .irq_active  (irq_active),
        .any_open    (level != '0),
        .top_ctx     (top_ctx),
        .redirect    (redirect),
        .redirect_pc (redirect_pc),
        .pop         (pop),
        .dec         (dec)
    );

    // The match acts first, then the start is pushed on what remains.
    assign level_after_pop = level - LVL_W'(pop);
    assign push            = start_valid && (level_after_pop < LVL_W'(DEPTH));
    assign overflow_evt    = start_valid && !push;
    assign open_next       = (level_after_pop + LVL_W'(push)) != '0;

    loop_ctx_stack #(.DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .dec      (dec),
        .push_ctx (new_ctx),
        .level    (level),
        .top_ctx  (top_ctx)
    );

    loop_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_active   (irq_active),
        .open_next    (open_next),
        .overflow_evt (overflow_evt),
        .in_loop      (in_loop),
        .overflow_err (overflow_err)
    );

    assign lc_value   = top_ctx.lc;
    assign nest_level = level;
endmodule

// File: rtl/loop_ctrl_checker.sv
module loop_ctrl_checker
    import loop_pkg::*;
#(
    parameter int unsigned DEPTH = LP_DEPTH,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_valid,
    input logic                 fetch_valid,
    input logic                 irq_active,
    input logic                 redirect,
    input logic [LP_CNT_W-1:0]  lc_value,
    input logic                 in_loop,
    input logic [LVL_W-1:0]     nest_level,
    input logic                 overflow_err
);
    assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && (nest_level < LVL_W'(DEPTH)) |=> in_loop && (nest_level != '0));

    assert_redirect_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        redirect && !start_valid |=> lc_value == $past(lc_value) - LP_CNT_W'(1));

    assert_open_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_level != '0) == in_loop);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid && !fetch_valid && (nest_level == LVL_W'(DEPTH))
        |=> overflow_err && (nest_level == LVL_W'(DEPTH)));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    assert_irq_no_jump_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_active |-> !redirect);

    assert_irq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_active && !start_valid |=> $stable(lc_value) && $stable(nest_level));

    assert_no_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |-> !redirect);
endmodule

bind loop_ctrl loop_ctrl_checker #(.DEPTH(DEPTH)) u_loop_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_valid  (start_valid),
    .fetch_valid  (fetch_valid),
    .irq_active   (irq_active),
    .redirect     (redirect),
    .lc_value     (lc_value),
    .in_loop      (in_loop),
    .nest_level   (nest_level),
    .overflow_err (overflow_err)
);

// File: tb/test_loop_ctrl.sv
`timescale 1ns/100ps
module test_loop_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_imm = 1'b0;
    logic [15:0] start_count = '0;
    logic [15:0] start_pc = '0;
    logic [15:0] start_end = '0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic        irq_active = 1'b0;
    logic        redirect;
    logic [15:0] redirect_pc;
    logic [15:0] lc_value;
    logic        in_loop;
    logic [2:0]  nest_level;
    logic        overflow_err;

    int total = 0;
    int bad = 0;
    logic        r_redir;
    logic [15:0] r_rpc;

    always #2.5 clk = ~clk;

    loop_ctrl i_loop_ctrl (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_imm(start_imm),
        .start_count(start_count), .start_pc(start_pc), .start_end(start_end),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc), .irq_active(irq_active),
        .redirect(redirect), .redirect_pc(redirect_pc), .lc_value(lc_value),
        .in_loop(in_loop), .nest_level(nest_level), .overflow_err(overflow_err)
    );

    // count, imm flag, expected passes
    localparam int NV = 6;
    localparam int V_CNT  [NV] = '{0, 3, 'h00FF, 'hAB05, 999, 'h0100};
    localparam int V_IMM  [NV] = '{0, 0, 1, 1, 0, 1};
    localparam int V_PASS [NV] = '{1, 4, 256, 6, 1000, 1};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic sv, input logic si, input logic [15:0] cnt,
                       input logic [15:0] spc, input logic [15:0] send,
                       input logic fv, input logic [15:0] fpc);
        start_valid = sv; start_imm = si; start_count = cnt;
        start_pc = spc; start_end = send; fetch_valid = fv; fetch_pc = fpc;
        #1;
        r_redir = redirect;
        r_rpc   = redirect_pc;
        @(posedge clk); #1;
        start_valid = 1'b0; fetch_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_active = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] pc;
        int passes, inner, outer, guard;
        @(posedge clk); #1;
        // R1 reset state
        check(nest_level == 0 && in_loop == 0 && lc_value == 0 && overflow_err == 0,
              "R1 reset", nest_level, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // Table walk: single loops, body at 0x22..0x23, command at 0x20
        for (int v = 0; v < NV; v++) begin
            do_reset();
            cyc(1, V_IMM[v][0], V_CNT[v][15:0], 16'h0020, 16'h0023, 0, 0);
            check(lc_value == 16'(V_PASS[v] - 1), V_IMM[v] != 0 ? "R3 imm load" : "R2 load",
                  lc_value, V_PASS[v] - 1);
            check(in_loop == 1 && nest_level == 1, "R2 open", nest_level, 1);
            pc = 16'h0022; passes = 0; guard = 0;
            while (guard < 5000) begin
                guard++;
                cyc(0, 0, 0, 0, 0, 1, pc);
                if (pc == 16'h0023) begin
                    passes++;
                    if (r_redir) begin
                        if (passes == 1)
                            check(r_rpc == 16'h0022, "R4 redirect_pc", r_rpc, 16'h22);
                        pc = r_rpc;
                    end else break;
                end else pc = pc + 1;
            end
            check(passes == V_PASS[v], "R4 pass count", passes, V_PASS[v]);
            check(nest_level == 0 && in_loop == 0, "R5 pop to idle", nest_level, 0);
        end

        // R10: no loop open, and fetch_valid low
        do_reset();
        cyc(0, 0, 0, 0, 0, 1, 16'h0000);
        check(r_redir == 0, "R10 idle fetch", r_redir, 0);
        cyc(1, 0, 16'd5, 16'h0040, 16'h0045, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 16'h0045);
        check(r_redir == 0 && lc_value == 5, "R10 no fetch_valid", lc_value, 5);

        // Nested: outer cmd 0x100 end 0x10A count 1, inner cmd 0x102 end 0x105 count 2
        do_reset();
        pc = 16'h0100; inner = 0; outer = 0; guard = 0;
        while (pc != 16'h010B && guard < 200) begin
            guard++;
            if (pc == 16'h0100) begin
                cyc(1, 0, 16'd1, 16'h0100, 16'h010A, 0, 0); pc = 16'h0102;
            end else if (pc == 16'h0102) begin
                cyc(1, 0, 16'd2, 16'h0102, 16'h0105, 0, 0); pc = 16'h0104;
                check(nest_level == 2 && lc_value == 2, "R2 nested push", nest_level, 2);
            end else begin
                if (pc == 16'h0106 && outer == 0)
                    check(nest_level == 1 && lc_value == 1 && in_loop == 1,
                          "R6 restore outer", lc_value, 1);
                cyc(0, 0, 0, 0, 0, 1, pc);
                if (pc == 16'h0105) inner++;
                if (pc == 16'h010A) outer++;
                pc = r_redir ? r_rpc : pc + 1;
            end
        end
        check(inner == 6, "R6 inner passes", inner, 6);
        check(outer == 2, "R6 outer passes", outer, 2);
        check(nest_level == 0 && in_loop == 0, "R6 final idle", nest_level, 0);

        // R7 overflow
        do_reset();
        for (int k = 0; k < 4; k++)
            cyc(1, 0, 16'(10 + k), 16'(16'h0200 + 16'(k * 2)), 16'h0210, 0, 0);
        check(nest_level == 4 && overflow_err == 0, "R7 full depth", nest_level, 4);
        cyc(1, 0, 16'd99, 16'h0300, 16'h0310, 0, 0);
        check(overflow_err == 1, "R7 flag", overflow_err, 1);
        check(nest_level == 4 && lc_value == 13, "R7 ignored", lc_value, 13);
        cyc(0, 0, 0, 0, 0, 0, 0);
        check(overflow_err == 1, "R7 sticky", overflow_err, 1);

        // R8 interrupt
        do_reset();
        cyc(1, 0, 16'd2, 16'h0300, 16'h0305, 0, 0);
        irq_active = 1'b1;
        cyc(0, 0, 0, 0, 0, 1, 16'h0305);
        check(r_redir == 0, "R8 no redirect", r_redir, 0);
        check(lc_value == 2 && nest_level == 1 && in_loop == 1, "R8 held", lc_value, 2);
        irq_active = 1'b0;
        cyc(0, 0, 0, 0, 0, 1, 16'h0305);
        check(r_redir == 1 && r_rpc == 16'h0302, "R8 resume", r_rpc, 16'h0302);
        check(lc_value == 1, "R4 dec after resume", lc_value, 1);

        // R9 same-cycle pop and start
        do_reset();
        cyc(1, 0, 16'd0, 16'h0400, 16'h0403, 0, 0);
        cyc(1, 0, 16'd7, 16'h0500, 16'h0510, 1, 16'h0403);
        check(r_redir == 0, "R9 no redirect", r_redir, 0);
        check(nest_level == 1 && lc_value == 7, "R9 replace top", lc_value, 7);
        cyc(0, 0, 0, 0, 0, 1, 16'h0510);
        check(r_redir == 1 && r_rpc == 16'h0502, "R9 new loop jump", r_rpc, 16'h0502);

        // R9 same-cycle redirect and start
        do_reset();
        cyc(1, 0, 16'd3, 16'h0600, 16'h0603, 0, 0);
        cyc(1, 0, 16'd5, 16'h0700, 16'h0710, 1, 16'h0603);
        check(r_redir == 1 && nest_level == 2 && lc_value == 5, "R9 dec then push", nest_level, 2);
        cyc(0, 0, 0, 0, 0, 1, 16'h0710);
        cyc(0, 0, 0, 0, 0, 1, 16'h0710);
        cyc(0, 0, 0, 0, 0, 1, 16'h0710);
        cyc(0, 0, 0, 0, 0, 1, 16'h0710);
        cyc(0, 0, 0, 0, 0, 1, 16'h0710);
        cyc(0, 0, 0, 0, 0, 1, 16'h0710);
        check(nest_level == 1 && lc_value == 2, "R9 outer decremented once", lc_value, 2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule